// File: doc/BRIEF.md
# Keyed-Write Watchdog Timer

This block is a watchdog built around an 8-bit up-counter. The counter advances once per prescaler period, and the period is one of eight power-of-two divisions of the block clock. Software keeps the watchdog from expiring by reloading the counter before it wraps from 0xFF to 0x00. A wrap sets a sticky flag. Depending on a mode bit, it then either pulses a reset request for one cycle or holds an interrupt request until software clears the flag.

Both registers accept only 16-bit writes whose upper byte carries a key of fixed value. The counter's key is 0x5A and the control register's key is 0xA5. Any other write leaves the register as it was, so a stray or partial store cannot disturb the timer. Reads return one byte, which is selected by a target input.

The overflow action is sequenced by a small state machine. ST_STOP is the state while the enable bit is clear. ST_RUN is the state while counting. ST_FIRE lasts one cycle after a wrap. The transitions are:
- ST_STOP→ST_RUN when enable is set.
- ST_RUN→ST_STOP when enable is cleared.
- ST_RUN→ST_FIRE on a wrap.
- ST_FIRE→ST_RUN, or ST_FIRE→ST_STOP if enable has been cleared.

Top module: `kwdt_top`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00 (clock select 0, divide by 32), and irq_req and rst_req are low.
- R2: A write with wr_wide=1, wr_tgt=0 and wr_data[15:8]=0x5A loads wr_data[7:0] into the counter. The new count is readable after the write edge.
- R3: A write with wr_wide=1, wr_tgt=1 and wr_data[15:8]=0xA5 updates the control register. The control register bits are:
  - bit 7: overflow flag
  - bit 6: mode
  - bit 5: enable
  - bits 4:3: read as 0
  - bits 2:0: clock select
- R4: A write whose upper byte does not match the target's key, or any write with wr_wide=0, leaves the targeted register unchanged.
- R5: While enable is set, clock select value s makes the counter increment every 32·2^s cycles. The first increment comes 32·2^s cycles after the edge that set enable.
- R6: While enable is clear, the counter holds its value and the prescaler is held at zero. Re-enabling gives a full period before the next increment.
- R7: A wrap from 0xFF to 0x00 sets the overflow flag, and the flag stays set. Only a keyed control write with bit 7 = 0 clears it. A keyed write with bit 7 = 1 never sets it.
- R8: With mode = 1, rst_req is high for exactly the one cycle after the wrap edge.
- R9: With mode = 0, irq_req follows the overflow flag: it rises after the wrap edge and falls after the clearing write.
- R10: A keyed control write that changes the clock select restarts the prescaler from zero, so the next increment comes one full new period after that write. A write that leaves the select unchanged does not restart it.
- R11: When a keyed counter write lands on the same edge as a prescaler tick, the written value wins and no overflow is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| wr_tgt | input | 1 | Write target: 0 counter, 1 control |
| wr_data | input | 16 | Write data; upper byte is the key |
| rd_tgt | input | 1 | Read target: 0 counter, 1 control |
| rd_data | output | 8 | Selected register value (combinational) |
| irq_req | output | 1 | Interrupt request level (mode 0) |
| rst_req | output | 1 | One-cycle reset request (mode 1) |

## Verification
Register writes are visible on rd_data in the half cycle after their write edge. With clock select s, a counter increment lands exactly 32·2^s edges after enabling, after a select change, or after the previous increment. The flag, irq_req and rst_req all change on that same edge, and rst_req drops one edge later. Every scenario counts edges from the write edge and samples on falling edges. Each check samples both one cycle before and at the edge where a change is due, so an off-by-one period or an extra pipeline register is caught.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIRE = 2'd2
    } wd_state_e;

    localparam int unsigned DEF_CNT_W     = 8;
    localparam int unsigned DEF_SEL_W     = 3;
    localparam int unsigned DEF_BASE_LOG2 = 5;

endpackage

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler #(
    parameter int unsigned SEL_W     = 3,
    parameter int unsigned BASE_LOG2 = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);
    localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;
    localparam int unsigned PRE_W   = BASE_LOG2 + MAX_SEL;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] limit;

    // Terminal count for divide ratio 2^(BASE_LOG2+sel), minus one
    always_comb begin
        limit = {PRE_W{1'b1}} >> (SEL_W'(MAX_SEL) - sel_i);
    end

    assign tick_o = run_i && !restart_i && (pre_q == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run_i || restart_i) begin
            pre_q <= '0;
        end else if (pre_q == limit) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R6: prescaler is parked at zero while counting is disabled
    a_r6_prescaler_parked: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (pre_q == '0));

    // R10: a restart always leaves the prescaler at zero
    a_r10_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> (pre_q == '0) && !tick_o);

endmodule

// File: rtl/kwdt_regs.sv
module kwdt_regs #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned SEL_W   = 3,
    parameter logic [CNT_W-1:0] KEY_CNT = 8'h5A,
    parameter logic [CNT_W-1:0] KEY_CSR = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_wide,
    input  logic               wr_tgt,
    input  logic [2*CNT_W-1:0] wr_data,
    input  logic               rd_tgt,
    input  logic               tick_i,
    output logic [CNT_W-1:0]   rd_data,
    output logic               en_o,
    output logic               mode_o,
    output logic               flag_o,
    output logic [SEL_W-1:0]   sel_o,
    output logic               sel_chg_o,
    output logic               wrap_o
);
    localparam int unsigned FLAG_B = CNT_W - 1;
    localparam int unsigned MODE_B = CNT_W - 2;
    localparam int unsigned EN_B   = CNT_W - 3;
    localparam int unsigned PAD_W  = CNT_W - 3 - SEL_W;

    logic [CNT_W-1:0] cnt_q;
    logic             flag_q, mode_q, en_q;
    logic [SEL_W-1:0] sel_q;

    logic [CNT_W-1:0] key_b, low_b;
    logic             cnt_load, csr_load;

    assign key_b = wr_data[2*CNT_W-1:CNT_W];
    assign low_b = wr_data[CNT_W-1:0];

    assign cnt_load = wr_en && wr_wide && !wr_tgt && (key_b == KEY_CNT);
    assign csr_load = wr_en && wr_wide &&  wr_tgt && (key_b == KEY_CSR);

    assign sel_chg_o = csr_load && (low_b[SEL_W-1:0] != sel_q);
    assign wrap_o    = tick_i && !cnt_load && (cnt_q == {CNT_W{1'b1}});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cnt_load) begin
            cnt_q <= low_b;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            mode_q <= 1'b0;
            en_q   <= 1'b0;
            sel_q  <= '0;
        end else begin
            if (csr_load) begin
                mode_q <= low_b[MODE_B];
                en_q   <= low_b[EN_B];
                sel_q  <= low_b[SEL_W-1:0];
            end
            if (wrap_o) begin
                flag_q <= 1'b1;
            end else if (csr_load && !low_b[FLAG_B]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        if (rd_tgt) begin
            rd_data = {flag_q, mode_q, en_q, {PAD_W{1'b0}}, sel_q};
        end else begin
            rd_data = cnt_q;
        end
    end

    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign flag_o = flag_q;
    assign sel_o  = sel_q;

    // R6: counter frozen while disabled and not written
    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_q && !cnt_load) |=> (cnt_q == $past(cnt_q)));

    // R7: flag stays set unless a keyed clearing write arrives
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !(csr_load && !low_b[FLAG_B])) |=> flag_q);

    // R4: rejected control writes leave the control fields untouched
    a_r4_csr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_tgt && !csr_load && !wrap_o) |=>
        ($stable(flag_q) && $stable(mode_q) && $stable(en_q) && $stable(sel_q)));

    // R11: a keyed counter write never coincides with a recorded wrap
    a_r11_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_load |=> (cnt_q == $past(low_b)));

endmodule

// File: rtl/kwdt_fsm.sv
module kwdt_fsm
    import kwdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic wrap_i,
    input  logic mode_i,
    input  logic flag_i,
    output logic irq_req,
    output logic rst_req
);
    wd_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (en_i) state_d = ST_RUN;
            ST_RUN: begin
                if (wrap_i)     state_d = ST_FIRE;
                else if (!en_i) state_d = ST_STOP;
            end
            ST_FIRE: begin
                if (wrap_i)     state_d = ST_FIRE;
                else if (en_i)  state_d = ST_RUN;
                else            state_d = ST_STOP;
            end
            default: state_d = ST_STOP;
        endcase
    end

    always_comb begin
        rst_req = (state_q == ST_FIRE) && mode_i;
        irq_req = flag_i && !mode_i;
    end

    // R8: a wrap moves the machine into the firing state
    a_r8_wrap_fires: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_i |=> (state_q == ST_FIRE));

    // R8: reset request never lasts more than one cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R6: no wrap is seen while counting is off
    a_r6_no_wrap_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |-> !wrap_i);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
    parameter int unsigned CNT_W     = kwdt_pkg::DEF_CNT_W,
    parameter int unsigned SEL_W     = kwdt_pkg::DEF_SEL_W,
    parameter int unsigned BASE_LOG2 = kwdt_pkg::DEF_BASE_LOG2,
    parameter logic [CNT_W-1:0] KEY_CNT = 8'h5A,
    parameter logic [CNT_W-1:0] KEY_CSR = 8'hA5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               wr_wide,
    input  logic               wr_tgt,
    input  logic [2*CNT_W-1:0] wr_data,
    input  logic               rd_tgt,
    output logic [CNT_W-1:0]   rd_data,
    output logic               irq_req,
    output logic               rst_req
);
    logic             tick, wrap, sel_chg;
    logic             en, mode, flag;
    logic [SEL_W-1:0] sel;

    kwdt_regs #(
        .CNT_W   (CNT_W),
        .SEL_W   (SEL_W),
        .KEY_CNT (KEY_CNT),
        .KEY_CSR (KEY_CSR)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_wide   (wr_wide),
        .wr_tgt    (wr_tgt),
        .wr_data   (wr_data),
        .rd_tgt    (rd_tgt),
        .tick_i    (tick),
        .rd_data   (rd_data),
        .en_o      (en),
        .mode_o    (mode),
        .flag_o    (flag),
        .sel_o     (sel),
        .sel_chg_o (sel_chg),
        .wrap_o    (wrap)
    );

    kwdt_prescaler #(
        .SEL_W     (SEL_W),
        .BASE_LOG2 (BASE_LOG2)
    ) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (en),
        .restart_i (sel_chg),
        .sel_i     (sel),
        .tick_o    (tick)
    );

    kwdt_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en),
        .wrap_i  (wrap),
        .mode_i  (mode),
        .flag_i  (flag),
        .irq_req (irq_req),
        .rst_req (rst_req)
    );

    // R9: interrupt level only appears in interrupt mode
    a_r9_irq_mode: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> !rst_req);

endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        wr_wide = 1'b0;
    logic        wr_tgt = 1'b0;
    logic [15:0] wr_data = '0;
    logic        rd_tgt = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_req, rst_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kwdt_top dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_wide (wr_wide),
        .wr_tgt  (wr_tgt),
        .wr_data (wr_data),
        .rd_tgt  (rd_tgt),
        .rd_data (rd_data),
        .irq_req (irq_req),
        .rst_req (rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One write; returns at the falling edge right after the write edge
    task automatic do_wr(input bit tgt, input bit wide, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_tgt = tgt; wr_wide = wide; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_wide = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input bit tgt, output int v);
        rd_tgt = tgt;
        #1;
        v = rd_data;
    endtask

    task automatic t_reset();
        int v;
        rd(0, v); chk("R1 count", v, 8'h00);
        rd(1, v); chk("R1 control", v, 8'h00);
        chk("R1 irq", irq_req, 0);
        chk("R1 rst_req", rst_req, 0);
    endtask

    task automatic t_keys();
        int v;
        do_wr(0, 1, 16'h5A33); rd(0, v); chk("R2 keyed count load", v, 8'h33);
        do_wr(1, 1, 16'hA55B); rd(1, v); chk("R3 control fields, pad zero", v, 8'h43);
        do_wr(0, 1, 16'h5B77); rd(0, v); chk("R4 wrong count key", v, 8'h33);
        do_wr(0, 0, 16'h5A77); rd(0, v); chk("R4 byte write count", v, 8'h33);
        do_wr(1, 1, 16'h5A24); rd(1, v); chk("R4 wrong control key", v, 8'h43);
        do_wr(1, 0, 16'hA524); rd(1, v); chk("R4 byte write control", v, 8'h43);
        wait_cyc(100);
        rd(0, v); chk("R6 disabled count holds", v, 8'h33);
        do_wr(1, 1, 16'hA500);
    endtask

    task automatic t_first_tick();
        int v;
        do_wr(0, 1, 16'h5A10);
        do_wr(1, 1, 16'hA520);           // enable, /32
        wait_cyc(31); rd(0, v); chk("R5 before first tick", v, 8'h10);
        wait_cyc(1);  rd(0, v); chk("R5 first tick at 32", v, 8'h11);
        wait_cyc(31); rd(0, v); chk("R5 before second tick", v, 8'h11);
        wait_cyc(1);  rd(0, v); chk("R5 second tick at 64", v, 8'h12);
        // disable mid-period, re-enable later: full period again
        wait_cyc(9);
        do_wr(1, 1, 16'hA500);
        wait_cyc(50); rd(0, v); chk("R6 hold while off", v, 8'h12);
        do_wr(1, 1, 16'hA520);
        wait_cyc(31); rd(0, v); chk("R6 full period after re-enable", v, 8'h12);
        wait_cyc(1);  rd(0, v); chk("R6 tick after re-enable", v, 8'h13);
        do_wr(1, 1, 16'hA500);
    endtask

    task automatic t_sel_change();
        int v;
        do_wr(0, 1, 16'h5A00);
        do_wr(1, 1, 16'hA521);           // /64
        wait_cyc(39);
        do_wr(1, 1, 16'hA522);           // /128, restart
        wait_cyc(127); rd(0, v); chk("R10 no tick before new period", v, 8'h00);
        wait_cyc(1);   rd(0, v); chk("R10 tick after new period", v, 8'h01);
        do_wr(1, 1, 16'hA500);
        do_wr(1, 1, 16'hA520);           // /32 from zero
        wait_cyc(9);
        do_wr(1, 1, 16'hA520);           // same select: no restart
        wait_cyc(21); rd(0, v); chk("R10 same select keeps phase", v, 8'h02);
        do_wr(1, 1, 16'hA500);
    endtask

    task automatic t_reset_mode();
        int v;
        do_wr(0, 1, 16'h5AFF);
        do_wr(1, 1, 16'hA560);           // mode reset, enable, /32
        wait_cyc(31);
        chk("R8 no pulse before wrap", rst_req, 0);
        wait_cyc(1);
        chk("R8 pulse after wrap", rst_req, 1);
        chk("R9 no irq in reset mode", irq_req, 0);
        rd(0, v); chk("R7 wrap to zero", v, 8'h00);
        rd(1, v); chk("R7 flag set", v, 8'hE0);
        wait_cyc(1);
        chk("R8 pulse one cycle", rst_req, 0);
        do_wr(1, 1, 16'hA500);
        rd(1, v); chk("R7 flag cleared", v, 8'h00);
    endtask

    task automatic t_irq_mode_slow();
        int v;
        do_wr(0, 1, 16'h5AFF);
        do_wr(1, 1, 16'hA527);           // irq mode, enable, /4096
        wait_cyc(4095);
        rd(0, v); chk("R5 /4096 not yet", v, 8'hFF);
        chk("R9 irq low before wrap", irq_req, 0);
        wait_cyc(1);
        rd(0, v); chk("R5 /4096 wrap", v, 8'h00);
        chk("R9 irq high after wrap", irq_req, 1);
        chk("R8 no pulse in irq mode", rst_req, 0);
        do_wr(1, 1, 16'hA5A7);           // bit7=1 keeps flag
        chk("R7 write one keeps flag", irq_req, 1);
        do_wr(1, 1, 16'hA527);
        chk("R9 irq cleared", irq_req, 0);
        do_wr(1, 1, 16'hA580);           // bit7=1 with flag clear
        rd(1, v); chk("R7 write one never sets", v, 8'h00);
    endtask

    task automatic t_collide();
        int v;
        do_wr(0, 1, 16'h5AFF);
        do_wr(1, 1, 16'hA520);
        wait_cyc(30);
        do_wr(0, 1, 16'h5A40);           // write edge is the tick edge (32)
        rd(0, v); chk("R11 write wins over tick", v, 8'h40);
        rd(1, v); chk("R11 no flag on collision", v, 8'h20);
        chk("R11 no irq on collision", irq_req, 0);
        do_wr(1, 1, 16'hA500);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);
        t_reset();
        t_keys();
        t_first_tick();
        t_sel_change();
        t_reset_mode();
        t_irq_mode_slow();
        t_collide();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule